// File: doc/BRIEF.md
# Synchronous SRAM Read Path with Selectable Latency

This block is the data path of a small synchronous SRAM model. It keeps a registered address, an array written one byte lane at a time, an optional output data register and a modelled tri-state output. A cycle is either selected (`cyc_en` high) or a deselect. A selected cycle with no byte strobe set is a read, and a selected cycle with any strobe set is a write. The address and the write data are taken on the same rising edge that samples the strobes.

A static mode pin picks the read latency. With `pipe_mode` high, read data passes through an output register and appears one clock after the address is registered. With `pipe_mode` low, that register is bypassed and the array output reaches the bus in the cycle in which the address is registered. The pin is never sampled by the clock. The output enable is also unclocked: the bus is driven only while it is high and the active stage holds a read. A write cycle floats the bus, and a deselect floats it one stage later.

Top module: `sram_rdpath`

## Requirements
- R1: While reset is held and after it is released, `dq_drive` is 0 until a read reaches the output stage.
- R2: With `pipe_mode` = 0, a read registered on rising edge k drives the word at that address on `dq_out` with `dq_drive` = 1 right after edge k.
- R3: With `pipe_mode` = 1, a read registered on edge k is driven right after edge k+1. Right after edge k the bus still shows the state of the previous cycle.
- R4: `byte_we` bit i writes lane i, which is data bits 8i+7 down to 8i, at the addressed word on the sampling edge. Lanes whose bit is 0 keep their stored value.
- R5: `dq_drive` is the logical AND of `oe` with the read state of the active stage. It follows `oe` between clock edges with no clock needed.
- R6: After an edge that samples a write (`cyc_en` = 1 and `byte_we` not 0), `dq_drive` is 0 until the next edge, in either mode and whatever `oe` is. In pipelined mode this also drops the data of a read made on the edge before.
- R7: After a deselect edge (`cyc_en` = 0), `dq_drive` is 0 in flow-through mode. In pipelined mode, the data of a read made on the edge before is still driven for that one cycle, and the bus floats after the second consecutive deselect edge.
- R8: A read of an address written on an earlier edge returns the newly written data, in both modes.
- R9: Write data is taken only on the strobe edge. Changing `wdata` afterwards does not change the stored word.
- R10: In pipelined mode, reads on consecutive edges deliver one word per cycle in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control and output registers |
| pipe_mode | input | 1 | Static latency select: 1 = pipelined, 0 = flow-through |
| cyc_en | input | 1 | Cycle select; 0 = deselect |
| addr | input | ADDR_W (8) | Word address, registered on selected cycles |
| byte_we | input | LANES (4) | Per-lane write strobes, active high |
| wdata | input | DATA_W (32) | Write data |
| oe | input | 1 | Unclocked output enable, active high |
| dq_out | output | DATA_W (32) | Data bus value |
| dq_drive | output | 1 | High when the bus is driven, low for high impedance |

## Verification
A lost or extra stage bit shows at once as `dq_drive` asserting one edge early or late around a read, write or deselect. A bad output register shows in pipelined mode as the previous word or a neighbouring word appearing one cycle after the read. A fault in lane decode or write capture stays hidden in the array until that address is read again, so every write in the stimulus is followed by a read-back in both modes. Holding `oe` low or swapping it in the middle of a cycle exposes any path that drives the bus without the enable.

// File: rtl/sram_rdpath_pkg.sv
package sram_rdpath_pkg;

  // A selected cycle is a write when any lane strobe is set.
  function automatic logic is_write(input logic sel, input logic [7:0] strobes);
    return sel && (strobes != '0);
  endfunction

  // A selected cycle with no strobe set is a read.
  function automatic logic is_read(input logic sel, input logic [7:0] strobes);
    return sel && (strobes == '0);
  endfunction

  // Which stage owns the bus in the selected mode.
  function automatic logic stage_live(input logic pipelined, input logic s1, input logic s2);
    return pipelined ? s2 : s1;
  endfunction

endpackage

// File: rtl/sram_rdpath_ctl.sv
module sram_rdpath_ctl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we,
  output logic              read_req,
  output logic              write_req,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_s1,
  output logic              rd_s2,
  output logic              wr_q
);
  import sram_rdpath_pkg::*;

  logic [7:0] strobes_w;

  always_comb begin
    strobes_w = '0;
    strobes_w[LANES-1:0] = byte_we;
  end

  assign read_req  = is_read(cyc_en, strobes_w);
  assign write_req = is_write(cyc_en, strobes_w);

  // Address register loads only on selected cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cyc_en) begin
      addr_q <= addr;
    end
  end

  // Stage 1: read state of the registered cycle; stage 2: one edge later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s1 <= 1'b0;
      rd_s2 <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      rd_s1 <= read_req;
      rd_s2 <= rd_s1;
      wr_q  <= write_req;
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wlane,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rlane
);
  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wlane;
    end
  end

  assign rlane = cells[raddr];

endmodule

// File: rtl/sram_rdpath_out.sv
module sram_rdpath_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              rd_s1,
  input  logic              rd_s2,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  import sram_rdpath_pkg::*;

  logic [DATA_W-1:0] out_q;

  // Output data register, used only in pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= arr_rd_data;
    end
  end

  assign dq_out   = pipe_mode ? out_q : arr_rd_data;
  assign dq_drive = oe && !wr_q && stage_live(pipe_mode, rd_s1, rd_s2);

endmodule

// File: rtl/sram_rdpath.sv
module sram_rdpath #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              cyc_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic              read_req;
  logic              write_req;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_s1;
  logic              rd_s2;
  logic              wr_q;
  logic [DATA_W-1:0] arr_rd_data;

  sram_rdpath_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .addr     (addr),
    .byte_we  (byte_we),
    .read_req (read_req),
    .write_req(write_req),
    .addr_q   (addr_q),
    .rd_s1    (rd_s1),
    .rd_s2    (rd_s2),
    .wr_q     (wr_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_lane (
      .clk  (clk),
      .we   (cyc_en && byte_we[g]),
      .waddr(addr),
      .wlane(wdata[g*LANE_W +: LANE_W]),
      .raddr(addr_q),
      .rlane(arr_rd_data[g*LANE_W +: LANE_W])
    );
  end

  sram_rdpath_out #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_mode  (pipe_mode),
    .oe         (oe),
    .rd_s1      (rd_s1),
    .rd_s2      (rd_s2),
    .wr_q       (wr_q),
    .arr_rd_data(arr_rd_data),
    .dq_out     (dq_out),
    .dq_drive   (dq_drive)
  );

endmodule

// File: rtl/sram_rdpath_chk.sv
module sram_rdpath_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              cyc_en,
  input logic              oe,
  input logic              read_req,
  input logic              write_req,
  input logic [DATA_W-1:0] arr_rd_data,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_drive
);

  // R1: no drive while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_float_R1: assert (!dq_drive);
    end
  end

  assert_flow_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && dq_drive) |-> $past(read_req));

  assert_pipe_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dq_drive) |-> $past(read_req, 2));

  assert_pipe_data_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dq_drive) |-> (dq_out == $past(arr_rd_data)));

  assert_oe_gates_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_drive);

  assert_write_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(write_req) |-> !dq_drive);

  assert_flow_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(!cyc_en)) |-> !dq_drive);

  assert_pipe_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(!cyc_en) && $past(!cyc_en, 2)) |-> !dq_drive);

endmodule

bind sram_rdpath sram_rdpath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pipe_mode  (pipe_mode),
  .cyc_en     (cyc_en),
  .oe         (oe),
  .read_req   (read_req),
  .write_req  (write_req),
  .arr_rd_data(arr_rd_data),
  .dq_out     (dq_out),
  .dq_drive   (dq_drive)
);

// File: tb/sram_rdpath_bench.sv
`timescale 1ns/1ps
module sram_rdpath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_mode = 1'b0;
  logic        cyc_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  byte_we = '0;
  logic [31:0] wdata = '0;
  logic        oe = 1'b0;
  logic [31:0] dq_out;
  logic        dq_drive;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sram_rdpath u_sram_rdpath (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cyc_en(cyc_en),
    .addr(addr), .byte_we(byte_we), .wdata(wdata), .oe(oe),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  // {pipe, cyc, be[4], addr[8], wdata[32], oe, exp_drive, exp_data[32], req[4]}
  localparam int NV = 19;
  localparam logic [83:0] VEC [NV] = '{
    // flow-through section
    {1'b0,1'b1,4'hF,8'h10,32'h11223344,1'b1,1'b0,32'h0,4'd6},        // R6 write floats
    {1'b0,1'b1,4'h0,8'h10,32'h0,1'b1,1'b1,32'h11223344,4'd2},        // R2 R8 same-cycle read
    {1'b0,1'b1,4'h5,8'h10,32'hAABBCCDD,1'b1,1'b0,32'h0,4'd6},        // R6 partial write
    {1'b0,1'b1,4'h0,8'h10,32'h0,1'b1,1'b1,32'h11BB33DD,4'd4},        // R4 lane merge
    {1'b0,1'b1,4'hF,8'h20,32'h5A5A0F0F,1'b1,1'b0,32'h0,4'd6},        // R6
    {1'b0,1'b1,4'h0,8'h20,32'h0,1'b0,1'b0,32'h0,4'd5},               // R5 oe low
    {1'b0,1'b1,4'h0,8'h20,32'h0,1'b1,1'b1,32'h5A5A0F0F,4'd8},        // R8
    {1'b0,1'b0,4'h0,8'h00,32'h0,1'b1,1'b0,32'h0,4'd7},               // R7 flow deselect
    // pipelined section
    {1'b1,1'b1,4'hF,8'h30,32'hCAFEF00D,1'b1,1'b0,32'h0,4'd6},        // R6
    {1'b1,1'b1,4'h0,8'h30,32'h0,1'b1,1'b0,32'h0,4'd3},               // R3 not yet
    {1'b1,1'b1,4'h0,8'h10,32'h0,1'b1,1'b1,32'hCAFEF00D,4'd3},        // R3 R8 one later
    {1'b1,1'b1,4'h0,8'h20,32'h0,1'b1,1'b1,32'h11BB33DD,4'd10},       // R10 stream
    {1'b1,1'b0,4'h0,8'h00,32'h0,1'b1,1'b1,32'h5A5A0F0F,4'd7},        // R7 last word kept
    {1'b1,1'b0,4'h0,8'h00,32'h0,1'b1,1'b0,32'h0,4'd7},               // R7 floats
    {1'b1,1'b1,4'h0,8'h20,32'h0,1'b1,1'b0,32'h0,4'd3},               // R3
    {1'b1,1'b1,4'hF,8'h40,32'h01020304,1'b1,1'b0,32'h0,4'd6},        // R6 kills read
    {1'b1,1'b1,4'h0,8'h40,32'h0,1'b1,1'b0,32'h0,4'd3},               // R3
    {1'b1,1'b0,4'h0,8'h00,32'h0,1'b1,1'b1,32'h01020304,4'd8},        // R8
    {1'b1,1'b0,4'h0,8'h00,32'h0,1'b1,1'b0,32'h0,4'd7}                // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1 chk("R1 drive in reset", {31'b0, dq_drive}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 drive after reset", {31'b0, dq_drive}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pipe_mode = VEC[i][83];
      cyc_en    = VEC[i][82];
      byte_we   = VEC[i][81:78];
      addr      = VEC[i][77:70];
      wdata     = VEC[i][69:38];
      oe        = VEC[i][37];
      @(posedge clk); #1;
      chk($sformatf("R%0d vec%0d drive", VEC[i][3:0], i), {31'b0, dq_drive}, {31'b0, VEC[i][36]});
      if (VEC[i][36]) begin
        chk($sformatf("R%0d vec%0d data", VEC[i][3:0], i), dq_out, VEC[i][35:4]);
      end
    end

    // R5: oe acts without a clock (flow-through read held)
    @(negedge clk);
    pipe_mode = 1'b0; cyc_en = 1'b1; byte_we = 4'h0; addr = 8'h10; oe = 1'b1;
    @(posedge clk); #0.5;
    chk("R5 drive with oe", {31'b0, dq_drive}, 32'd1);
    oe = 1'b0; #0.5;
    chk("R5 oe dropped mid-cycle", {31'b0, dq_drive}, 32'd0);
    oe = 1'b1; #0.5;
    chk("R5 oe restored mid-cycle", {31'b0, dq_drive}, 32'd1);

    // R9: data changed after the strobe edge is not stored
    @(negedge clk);
    cyc_en = 1'b1; byte_we = 4'hF; addr = 8'h50; wdata = 32'h12345678;
    @(posedge clk); #1;
    wdata = 32'hFFFFFFFF; cyc_en = 1'b0; byte_we = 4'h0;
    @(negedge clk);
    cyc_en = 1'b1; addr = 8'h50;
    @(posedge clk); #1;
    chk("R9 stored word", dq_out, 32'h12345678);

    // R6: write sampled with oe high in flow mode
    @(negedge clk);
    byte_we = 4'h2; addr = 8'h50; wdata = 32'h0000AB00;
    @(posedge clk); #1;
    chk("R6 write floats with oe high", {31'b0, dq_drive}, 32'd0);
    @(negedge clk);
    byte_we = 4'h0;
    @(posedge clk); #1;
    chk("R4 single lane update", dq_out, 32'h1234AB78);

    // R8 in pipelined mode for the same address
    @(negedge clk);
    pipe_mode = 1'b1; cyc_en = 1'b0;
    @(negedge clk);
    cyc_en = 1'b1; addr = 8'h50;
    @(negedge clk);
    cyc_en = 1'b0;
    @(posedge clk); #1;
    chk("R8 pipelined read-back", dq_out, 32'h1234AB78);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule